// File: doc/BRIEF.md
# Five-Step Hardwired Instruction Sequencer

This block is the control section of a simple processor whose instructions run in five steps: fetch, decode, ALU, memory, writeback. A step counter moves forward one step per clock and wraps from step 5 back to step 1. Each cycle, combinational decode logic looks at the current step, the opcode and function field held in the instruction register, the ALU equality flag and the memory-done handshake. From these it produces the strobes and selects that steer the datapath.

A step that touches memory waits for the memory-done handshake. Those are step 1 (instruction fetch) and step 4 of a load or store. While the handshake is low, the counter stays in the same step and none of the PC, IR or register-file write enables is raised. Any step in which an instruction has no work drives every control output to zero. The datapath and the memory sit outside the block.

Top module: `hw_step_sequencer`

## Requirements
- R1: While `rst_n` is low, every control output is 0 and `step_o` reads 1.
- R2: `step_o` always lies in 1..5. When no memory wait is pending, it advances by one each clock and wraps from 5 to 1.
- R3: Step 1 drives `mem_rd_o`=1 and `addr_sel_rz_o`=0 (address from PC). When `mfc_i`=1, it also raises `ir_ld_o` and `pc_wr_o` with `pc_src_o`=0 (PC plus 4).
- R4: Step 2 drives every control output to 0 for every opcode.
- R5: In step 3, ALU-register (opcode 0x01) passes `alu_func_i` to `alu_fn_o` with `b_sel_imm_o`=0. ALU-immediate (0x02) does the same with `b_sel_imm_o`=1. Load (0x03) and store (0x04) drive `alu_fn_o`=0 (add) and `b_sel_imm_o`=1.
- R6: In step 3, branch (0x05) raises `pc_wr_o` with `pc_src_o`=1 (offset). Branch-if-equal (0x06) drives `alu_fn_o`=1 (compare) and `pc_src_o`=1, and raises `pc_wr_o` only when `cmp_eq_i`=1.
- R7: In step 3, call-register (0x07) and return (0x08) raise `pc_wr_o` with `pc_src_o`=2 (register).
- R8: In step 4, a load drives `mem_rd_o`=1, `addr_sel_rz_o`=1 and `y_sel_o`=1 (memory data). A store drives `mem_wr_o`=1 and `addr_sel_rz_o`=1. Read and write are never both high.
- R9: In a memory step with `mfc_i`=0, `step_o` holds and `pc_wr_o`, `ir_ld_o` and `rf_wr_o` stay 0. The access strobe stays high until the cycle in which `mfc_i` is 1, and the step advances on that clock.
- R10: Call-register drives `y_sel_o`=2 (return address) in step 4 and raises `rf_wr_o` with `rf_dst_link_o`=1 in step 5. ALU-register, ALU-immediate and load raise `rf_wr_o` with `rf_dst_link_o`=0 in step 5.
- R11: The following steps drive every control output to 0, and their step advances whatever `mfc_i` is:
  - step 4 of an ALU instruction;
  - step 5 of a store;
  - steps 4 and 5 of branch, branch-if-equal and return;
  - steps 3 to 5 of any other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| alu_func_i | input | 3 | ALU function field of the instruction register |
| cmp_eq_i | input | 1 | ALU equality flag |
| mfc_i | input | 1 | Memory function completed |
| step_o | output | 3 | Current step, 1..5 |
| pc_wr_o | output | 1 | PC write enable |
| ir_ld_o | output | 1 | IR load enable |
| rf_wr_o | output | 1 | Register-file write enable |
| rf_dst_link_o | output | 1 | Destination is the link register (else field C) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_rz_o | output | 1 | Memory address from RZ (else PC) |
| b_sel_imm_o | output | 1 | ALU B input from immediate (else register) |
| y_sel_o | output | 2 | RY source: 0 RZ, 1 memory data, 2 return address |
| pc_src_o | output | 2 | PC source: 0 plus 4, 1 offset, 2 register |
| alu_fn_o | output | 3 | ALU function: 0 add, 1 compare, else the function field |

## Verification
The assertions assume two things about the inputs. First, `opcode_i` and `alu_func_i` hold steady from step 2 through step 5, as an instruction register would. Second, `mfc_i` matters only in the memory steps.

The stimulus respects both. It changes the opcode only when a new fetch begins, and each instruction runs to completion. Fetch and data waits of several lengths are inserted, and `mfc_i` is toggled in steps that must ignore it, so that the hold and skip rules are exercised.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OPC_W     = 6;
    localparam int FN_W      = 3;
    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);

    localparam logic [OPC_W-1:0] OPC_ALU_R = 6'h01;
    localparam logic [OPC_W-1:0] OPC_ALU_I = 6'h02;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BR    = 6'h05;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h06;
    localparam logic [OPC_W-1:0] OPC_CALLR = 6'h07;
    localparam logic [OPC_W-1:0] OPC_RET   = 6'h08;

    localparam logic [1:0] PCS_INC = 2'd0;
    localparam logic [1:0] PCS_OFS = 2'd1;
    localparam logic [1:0] PCS_REG = 2'd2;

    localparam logic [1:0] YS_RZ  = 2'd0;
    localparam logic [1:0] YS_MEM = 2'd1;
    localparam logic [1:0] YS_RET = 2'd2;

    localparam logic [FN_W-1:0] ALU_ADD = 3'd0;
    localparam logic [FN_W-1:0] ALU_CMP = 3'd1;

    typedef struct packed {
        logic            pc_wr;
        logic            ir_ld;
        logic            rf_wr;
        logic            rf_link;
        logic            mem_rd;
        logic            mem_wr;
        logic            addr_rz;
        logic            b_imm;
        logic [1:0]      y_sel;
        logic [1:0]      pc_src;
        logic [FN_W-1:0] alu_fn;
    } ctrl_t;
endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);
    localparam logic [STEP_W-1:0] LAST  = STEP_W'(NUM_STEPS);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!hold_i) begin
            state_d.step = (state_q.step == LAST) ? FIRST : state_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{step: FIRST};
        else        state_q <= state_d;
    end

    assign step_o = state_q.step;

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o >= FIRST) && (step_o <= LAST)); // R2
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == LAST) && !hold_i |=> step_o == FIRST); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(step_o)); // R9
endmodule

// File: rtl/seq_ctrl_decode.sv
module seq_ctrl_decode
    import seq_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [FN_W-1:0]   alu_func_i,
    input  logic              cmp_eq_i,
    input  logic              mfc_i,
    output ctrl_t             ctrl_o,
    output logic              hold_o
);
    always_comb begin
        ctrl_o = '0;
        hold_o = 1'b0;
        case (step_i)
            STEP_W'(1): begin
                ctrl_o.mem_rd = 1'b1;
                if (mfc_i) begin
                    ctrl_o.ir_ld  = 1'b1;
                    ctrl_o.pc_wr  = 1'b1;
                    ctrl_o.pc_src = PCS_INC;
                end else begin
                    hold_o = 1'b1;
                end
            end
            STEP_W'(3): begin
                case (opcode_i)
                    OPC_ALU_R: ctrl_o.alu_fn = alu_func_i;
                    OPC_ALU_I: begin
                        ctrl_o.alu_fn = alu_func_i;
                        ctrl_o.b_imm  = 1'b1;
                    end
                    OPC_LOAD, OPC_STORE: begin
                        ctrl_o.alu_fn = ALU_ADD;
                        ctrl_o.b_imm  = 1'b1;
                    end
                    OPC_BR: begin
                        ctrl_o.pc_wr  = 1'b1;
                        ctrl_o.pc_src = PCS_OFS;
                    end
                    OPC_BEQ: begin
                        ctrl_o.alu_fn = ALU_CMP;
                        ctrl_o.pc_src = PCS_OFS;
                        ctrl_o.pc_wr  = cmp_eq_i;
                    end
                    OPC_CALLR, OPC_RET: begin
                        ctrl_o.pc_wr  = 1'b1;
                        ctrl_o.pc_src = PCS_REG;
                    end
                    default: ;
                endcase
            end
            STEP_W'(4): begin
                case (opcode_i)
                    OPC_LOAD: begin
                        ctrl_o.mem_rd  = 1'b1;
                        ctrl_o.addr_rz = 1'b1;
                        ctrl_o.y_sel   = YS_MEM;
                        hold_o         = !mfc_i;
                    end
                    OPC_STORE: begin
                        ctrl_o.mem_wr  = 1'b1;
                        ctrl_o.addr_rz = 1'b1;
                        hold_o         = !mfc_i;
                    end
                    OPC_CALLR: ctrl_o.y_sel = YS_RET;
                    default: ;
                endcase
            end
            STEP_W'(5): begin
                case (opcode_i)
                    OPC_ALU_R, OPC_ALU_I, OPC_LOAD: ctrl_o.rf_wr = 1'b1;
                    OPC_CALLR: begin
                        ctrl_o.rf_wr   = 1'b1;
                        ctrl_o.rf_link = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hw_step_sequencer.sv
module hw_step_sequencer
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       opcode_i,
    input  logic [2:0]       alu_func_i,
    input  logic             cmp_eq_i,
    input  logic             mfc_i,
    output logic [2:0]       step_o,
    output logic             pc_wr_o,
    output logic             ir_ld_o,
    output logic             rf_wr_o,
    output logic             rf_dst_link_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             addr_sel_rz_o,
    output logic             b_sel_imm_o,
    output logic [1:0]       y_sel_o,
    output logic [1:0]       pc_src_o,
    output logic [2:0]       alu_fn_o
);
    logic [STEP_W-1:0] step_q;
    logic              hold;
    ctrl_t             ctrl_dec;
    ctrl_t             ctrl_out;

    seq_step_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold),
        .step_o (step_q)
    );

    seq_ctrl_decode u_dec (
        .step_i     (step_q),
        .opcode_i   (opcode_i),
        .alu_func_i (alu_func_i),
        .cmp_eq_i   (cmp_eq_i),
        .mfc_i      (mfc_i),
        .ctrl_o     (ctrl_dec),
        .hold_o     (hold)
    );

    // Strobes are forced quiet while reset is held.
    assign ctrl_out = rst_n ? ctrl_dec : '0;

    assign step_o        = step_q;
    assign pc_wr_o       = ctrl_out.pc_wr;
    assign ir_ld_o       = ctrl_out.ir_ld;
    assign rf_wr_o       = ctrl_out.rf_wr;
    assign rf_dst_link_o = ctrl_out.rf_link;
    assign mem_rd_o      = ctrl_out.mem_rd;
    assign mem_wr_o      = ctrl_out.mem_wr;
    assign addr_sel_rz_o = ctrl_out.addr_rz;
    assign b_sel_imm_o   = ctrl_out.b_imm;
    assign y_sel_o       = ctrl_out.y_sel;
    assign pc_src_o      = ctrl_out.pc_src;
    assign alu_fn_o      = ctrl_out.alu_fn;

    AST_WAIT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) && !mfc_i |-> !(pc_wr_o || ir_ld_o || rf_wr_o)); // R9
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R8
    AST_STEP2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 3'd2) |-> (ctrl_out == '0)); // R4
    AST_FETCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 3'd1) |-> (mem_rd_o && !addr_sel_rz_o && !mem_wr_o)); // R3
endmodule

// File: tb/hw_step_sequencer_tb.sv
`timescale 1ns/1ps
module hw_step_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode_i = '0;
    logic [2:0] alu_func_i = '0;
    logic       cmp_eq_i = 1'b0;
    logic       mfc_i = 1'b0;
    logic [2:0] step_o;
    logic       pc_wr_o, ir_ld_o, rf_wr_o, rf_dst_link_o;
    logic       mem_rd_o, mem_wr_o, addr_sel_rz_o, b_sel_imm_o;
    logic [1:0] y_sel_o, pc_src_o;
    logic [2:0] alu_fn_o;

    int checks = 0;
    int fails  = 0;

    logic [14:0] exp_q[$];
    logic [2:0]  stp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    hw_step_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .alu_func_i(alu_func_i),
        .cmp_eq_i(cmp_eq_i), .mfc_i(mfc_i), .step_o(step_o), .pc_wr_o(pc_wr_o),
        .ir_ld_o(ir_ld_o), .rf_wr_o(rf_wr_o), .rf_dst_link_o(rf_dst_link_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .addr_sel_rz_o(addr_sel_rz_o),
        .b_sel_imm_o(b_sel_imm_o), .y_sel_o(y_sel_o), .pc_src_o(pc_src_o),
        .alu_fn_o(alu_fn_o)
    );

    function automatic logic [14:0] actual();
        return {pc_wr_o, ir_ld_o, rf_wr_o, rf_dst_link_o, mem_rd_o, mem_wr_o,
                addr_sel_rz_o, b_sel_imm_o, y_sel_o, pc_src_o, alu_fn_o};
    endfunction

    // Expected controls, built from the requirement text.
    function automatic logic [14:0] model(int s, logic [5:0] op, logic [2:0] fn,
                                          logic cmp, logic mfc);
        logic pc = 0, ir = 0, rf = 0, lk = 0, rd = 0, wr = 0, arz = 0, bi = 0;
        logic [1:0] ys = 0, ps = 0;
        logic [2:0] af = 0;
        case (s)
            1: begin rd = 1; if (mfc) begin ir = 1; pc = 1; end end
            3: case (op)
                6'h01: af = fn;
                6'h02: begin af = fn; bi = 1; end
                6'h03, 6'h04: begin af = 0; bi = 1; end
                6'h05: begin pc = 1; ps = 1; end
                6'h06: begin af = 1; ps = 1; pc = cmp; end
                6'h07, 6'h08: begin pc = 1; ps = 2; end
                default: ;
            endcase
            4: case (op)
                6'h03: begin rd = 1; arz = 1; ys = 1; end
                6'h04: begin wr = 1; arz = 1; end
                6'h07: ys = 2;
                default: ;
            endcase
            5: case (op)
                6'h01, 6'h02, 6'h03: rf = 1;
                6'h07: begin rf = 1; lk = 1; end
                default: ;
            endcase
            default: ;
        endcase
        return {pc, ir, rf, lk, rd, wr, arz, bi, ys, ps, af};
    endfunction

    function automatic string tag_for(int s, logic [5:0] op, logic mfc);
        case (s)
            1: return mfc ? "R3" : "R9";
            2: return "R4";
            3: case (op)
                6'h01, 6'h02, 6'h03, 6'h04: return "R5";
                6'h05, 6'h06: return "R6";
                6'h07, 6'h08: return "R7";
                default: return "R11";
            endcase
            4: case (op)
                6'h03, 6'h04: return mfc ? "R8" : "R9";
                6'h07: return "R10";
                default: return "R11";
            endcase
            default: case (op)
                6'h01, 6'h02, 6'h03, 6'h07: return "R10";
                default: return "R11";
            endcase
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and queue what must appear.
    task automatic one_cycle(int s, logic [5:0] op, logic [2:0] fn, logic cmp, logic mfc);
        opcode_i = op; alu_func_i = fn; cmp_eq_i = cmp; mfc_i = mfc;
        exp_q.push_back(model(s, op, fn, cmp, mfc));
        stp_q.push_back(3'(s));
        tag_q.push_back(tag_for(s, op, mfc));
        @(posedge clk); #1;
    endtask

    task automatic run_instr(logic [5:0] op, logic [2:0] fn, logic cmp, int w1, int w4);
        for (int i = 0; i < w1; i++) one_cycle(1, op, fn, cmp, 1'b0);
        one_cycle(1, op, fn, cmp, 1'b1);
        one_cycle(2, op, fn, cmp, 1'b1);   // handshake high must not matter
        one_cycle(3, op, fn, cmp, 1'b0);
        if (op == 6'h03 || op == 6'h04) begin
            for (int i = 0; i < w4; i++) one_cycle(4, op, fn, cmp, 1'b0);
            one_cycle(4, op, fn, cmp, 1'b1);
        end else begin
            one_cycle(4, op, fn, cmp, 1'b0); // no memory work: must not stall (R11)
        end
        one_cycle(5, op, fn, cmp, 1'b0);
    endtask

    // Monitor: compare at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [14:0] e;
            logic [2:0]  es;
            string       t;
            e = exp_q.pop_front(); es = stp_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (step_o !== es) begin
                fails++;
                $display("FAIL R2 step (%s): actual %0d expected %0d", t, step_o, es);
            end
            checks++;
            if (actual() !== e) begin
                fails++;
                $display("FAIL %s controls at step %0d: actual %b expected %b", t, es, actual(), e);
            end
        end
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset holds strobes low and step at 1
        mfc_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (actual() !== 15'd0 || step_o !== 3'd1) begin
            fails++;
            $display("FAIL R1 reset: actual step %0d ctrl %b expected step 1 ctrl 0", step_o, actual());
        end
        @(posedge clk); #1;
        rst_n = 1'b1;

        run_instr(6'h01, 3'd5, 1'b0, 0, 0);  // ALU register
        run_instr(6'h02, 3'd2, 1'b1, 2, 0);  // ALU immediate, fetch wait
        run_instr(6'h03, 3'd6, 1'b0, 0, 3);  // load, data wait
        run_instr(6'h04, 3'd1, 1'b0, 1, 2);  // store
        run_instr(6'h05, 3'd7, 1'b0, 0, 0);  // branch
        run_instr(6'h06, 3'd3, 1'b1, 0, 0);  // branch-if-equal taken
        run_instr(6'h06, 3'd3, 1'b0, 1, 0);  // branch-if-equal not taken
        run_instr(6'h07, 3'd0, 1'b1, 0, 0);  // call register
        run_instr(6'h08, 3'd4, 1'b0, 0, 0);  // return
        run_instr(6'h3F, 3'd7, 1'b1, 0, 0);  // unknown opcode
        run_instr(6'h03, 3'd2, 1'b1, 0, 0);  // load without wait
        run_instr(6'h04, 3'd0, 1'b0, 0, 0);  // store without wait

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule